// File: doc/BRIEF.md
# Circular Pre/Post-Trigger Capture Buffer

This block keeps a rolling record of a wide sample stream in on-chip memory. While armed it stores one sample word on every clock at a write address that steps up by one and returns to zero after the last location. The memory therefore always holds the most recent DEPTH words.

When a trigger pulse arrives, the block samples a post-trigger length A. It lets exactly A more words be written after the word stored on the trigger cycle, and then stops writing. The memory is then frozen with the trigger word, the DEPTH-1-A words before it and the A words after it. Every stored word belongs to the capture window, so the part before the trigger and the part after it always add up to the full depth.

Once frozen, the block reports the address of the final write. A readout port takes an index measured from the oldest stored word and returns that word. A re-arm pulse restarts recording from the address where writing stopped. The trigger decision and the host-side command handling belong to neighbouring blocks.

Top module: `tcap_top`

## Requirements
- R1: After reset the block is armed: `frozen` is 0, `stop_addr` is 0, and the first write after reset goes to address 0.
- R2: While not frozen, each clock writes `smp_data` to the current write address. The address then advances by one, and from DEPTH-1 it returns to 0.
- R3: A trigger seen while armed, with a post length A from 1 to DEPTH-1, makes the trigger-cycle word plus exactly A further words the last ones written. `stop_addr` then holds the address of the final write.
- R4: A trigger seen while armed with A = 0 makes the trigger-cycle word the final write. `stop_addr` equals that word's address.
- R5: `frozen` rises on the cycle after the final write, not before. It stays 1 until a re-arm is accepted.
- R6: While frozen nothing is written, and `stop_addr` and the write address hold. A trigger pulse in this state has no effect.
- R7: During the post-trigger count, further trigger pulses and re-arm pulses are ignored. The freeze happens exactly as scheduled by the first trigger.
- R8: Readout index k returns, one clock after `rd_index` is presented, the word stored at address (`stop_addr`+1+k) mod DEPTH. Index 0 is the oldest word, DEPTH-1 is the final write, and DEPTH-1-A is the trigger word.
- R9: A re-arm pulse while frozen clears `frozen` on the next cycle. Writing resumes at `stop_addr`+1 on the following clock, so older words beyond the new writes are kept.
- R10: The post length is taken only on the trigger cycle. Changes to `post_len` during the count do not move the stop point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | WIDTH | Sample word written each armed cycle |
| trig_in | input | 1 | Trigger pulse, sampled when armed |
| post_len | input | AW | Number of words to write after the trigger word |
| rearm | input | 1 | Restart recording after a freeze |
| rd_index | input | AW | Readout index counted from the oldest word |
| rd_word | output | WIDTH | Word selected by `rd_index`, one cycle later |
| frozen | output | 1 | Writing has stopped and the window is stable |
| stop_addr | output | AW | Address of the final write of the capture |

## Verification
The hardest case to reach from the ports is a window that mixes two recording runs: a re-arm followed almost at once by a zero-length trigger. Only then does a readout show the new words sitting directly after the old final word, which proves that writing resumed at the right address. The bench builds this case by releasing re-arm and raising the trigger on adjacent cycles. Every sample word carries its cycle number, so each readout identifies exactly which write it came from. A second scenario keeps the trigger and re-arm high and changes the post length throughout the count, and checks that the freeze still lands on the original cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   typedef enum logic [1:0] {
      CAP_ARMED  = 2'd0,
      CAP_POST   = 2'd1,
      CAP_FROZEN = 2'd2
   } cap_state_e;

endpackage

// File: rtl/tcap_ring_ptr.sv
module tcap_ring_ptr #(
   parameter  int unsigned DEPTH = 1024,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] ptr
);
   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [AW-1:0] ptr_inc;

   generate
      if (IS_POW2) begin : g_pow2
         assign ptr_inc = ptr + 1'b1;
      end else begin : g_cmp
         assign ptr_inc = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= ptr_inc;
   end
endmodule

// File: rtl/tcap_post_fsm.sv
module tcap_post_fsm #(
   parameter  int unsigned DEPTH = 1024,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic          rearm,
   input  logic [AW-1:0] post_len,
   input  logic [AW-1:0] cur_addr,
   output logic          wr_en,
   output logic          in_post,
   output logic          frozen,
   output logic [AW-1:0] stop_addr
);
   import tcap_pkg::*;

   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   cap_state_e    st;
   logic [AW-1:0] remain;
   logic [AW-1:0] len_eff;

   generate
      if (IS_POW2) begin : g_len_full
         assign len_eff = post_len;
      end else begin : g_len_sat
         assign len_eff = (post_len > AW'(DEPTH - 1)) ? AW'(DEPTH - 1) : post_len;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= CAP_ARMED;
         remain    <= '0;
         stop_addr <= '0;
      end else begin
         case (st)
            CAP_ARMED: begin
               if (trig) begin
                  if (len_eff == '0) begin
                     st        <= CAP_FROZEN;
                     stop_addr <= cur_addr;
                  end else begin
                     st     <= CAP_POST;
                     remain <= len_eff;
                  end
               end
            end
            CAP_POST: begin
               remain <= remain - 1'b1;
               if (remain == AW'(1)) begin
                  st        <= CAP_FROZEN;
                  stop_addr <= cur_addr;
               end
            end
            CAP_FROZEN: begin
               if (rearm) st <= CAP_ARMED;
            end
            default: st <= CAP_ARMED;
         endcase
      end
   end

   assign wr_en   = (st != CAP_FROZEN);
   assign in_post = (st == CAP_POST);
   assign frozen  = (st == CAP_FROZEN);
endmodule

// File: rtl/tcap_store.sv
module tcap_store #(
   parameter  int unsigned DEPTH   = 1024,
   parameter  int unsigned WIDTH   = 560,
   parameter  bit          OUT_REG = 1'b0,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      rd_q <= mem[rd_addr];
   end

   generate
      if (OUT_REG) begin : g_out_ff
         logic [WIDTH-1:0] rd_q2;
         always_ff @(posedge clk) rd_q2 <= rd_q;
         assign rd_data = rd_q2;
      end else begin : g_out_direct
         assign rd_data = rd_q;
      end
   endgenerate
endmodule

// File: rtl/tcap_top.sv
module tcap_top #(
   parameter  int unsigned DEPTH   = 1024,
   parameter  int unsigned WIDTH   = 560,
   parameter  bit          OUT_REG = 1'b0,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] smp_data,
   input  logic             trig_in,
   input  logic [AW-1:0]    post_len,
   input  logic             rearm,
   input  logic [AW-1:0]    rd_index,
   output logic [WIDTH-1:0] rd_word,
   output logic             frozen,
   output logic [AW-1:0]    stop_addr
);
   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("tcap_top: DEPTH must be at least 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tcap_top: WIDTH must be at least 1");
      end
   endgenerate

   logic          wr_en;
   logic          in_post;
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] idx_eff;
   logic [AW:0]   rd_sum;
   logic [AW-1:0] rd_phys;

   tcap_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (wr_en),
      .ptr   (wr_ptr)
   );

   tcap_post_fsm #(.DEPTH(DEPTH)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig_in),
      .rearm     (rearm),
      .post_len  (post_len),
      .cur_addr  (wr_ptr),
      .wr_en     (wr_en),
      .in_post   (in_post),
      .frozen    (frozen),
      .stop_addr (stop_addr)
   );

   generate
      if (IS_POW2) begin : g_idx_full
         assign idx_eff = rd_index;
      end else begin : g_idx_fold
         assign idx_eff = (rd_index >= AW'(DEPTH)) ? AW'(rd_index - AW'(DEPTH)) : rd_index;
      end
   endgenerate

   always_comb begin
      rd_sum = {1'b0, stop_addr} + (AW+1)'(1) + {1'b0, idx_eff};
      if (rd_sum >= (AW+1)'(DEPTH)) rd_phys = AW'(rd_sum - (AW+1)'(DEPTH));
      else                          rd_phys = AW'(rd_sum);
   end

   tcap_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_ptr),
      .wr_data (smp_data),
      .rd_addr (rd_phys),
      .rd_data (rd_word)
   );
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
   parameter  int unsigned DEPTH = 1024,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trig,
   input logic          rearm,
   input logic [AW-1:0] post_len,
   input logic          frozen,
   input logic          in_post,
   input logic [AW-1:0] wr_ptr,
   input logic [AW-1:0] stop_addr
);
   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
      return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
   endfunction

   // R2
   wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen |=> wr_ptr == nxt($past(wr_ptr)));

   // R6
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> $stable(wr_ptr) && $stable(stop_addr));

   // R5
   frozen_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen && !rearm |=> frozen);

   // R9
   rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen && rearm |=> !frozen);

   // R4
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen && !in_post && trig && post_len == '0 |=> frozen && stop_addr == $past(wr_ptr));

   // R3
   stop_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frozen) |-> wr_ptr == nxt(stop_addr));

   // R7
   post_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen && !in_post && trig && post_len != '0 |=> in_post && !frozen);
endmodule

bind tcap_top tcap_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig      (trig_in),
   .rearm     (rearm),
   .post_len  (post_len),
   .frozen    (frozen),
   .in_post   (in_post),
   .wr_ptr    (wr_ptr),
   .stop_addr (stop_addr)
);

// File: tb/sim_tcap_top.sv
module sim_tcap_top;
   localparam int D  = 1024;
   localparam int W  = 560;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   cyc = '0;
   logic [W-1:0]  smp_data;
   logic          trig_in = 1'b0;
   logic [AW-1:0] post_len = '0;
   logic          rearm = 1'b0;
   logic [AW-1:0] rd_index = '0;
   logic [W-1:0]  rd_word;
   logic          frozen;
   logic [AW-1:0] stop_addr;

   int n_chk = 0;
   int n_fail = 0;

   int          base_addr = 0;
   logic [15:0] base_cyc = '0;
   logic [15:0] g_T, g_last, g_r, prev_last;
   int          g_stop;

   assign smp_data = {35{cyc}};

   tcap_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_data  (smp_data),
      .trig_in   (trig_in),
      .post_len  (post_len),
      .rearm     (rearm),
      .rd_index  (rd_index),
      .rd_word   (rd_word),
      .frozen    (frozen),
      .stop_addr (stop_addr)
   );

   always #4 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) cyc = '0;
         else        cyc = cyc + 16'd1;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic read_chk(input int k, input logic [15:0] exp, input string tag);
      tick();
      rd_index = AW'(k);
      tick();
      check(rd_word == {35{exp}}, tag, $sformatf("readout index %0d", k),
            int'(rd_word[15:0]), int'(exp));
   endtask

   // Captures with post length A; disturb holds trig/rearm high and changes post_len during the count
   task automatic capture(input int A, input bit disturb);
      int exp_stop;
      tick();
      post_len = AW'(A);
      trig_in  = 1'b1;
      g_T      = cyc;
      tick();
      if (disturb) begin
         rearm    = 1'b1;   // R7: ignored during the count
         post_len = AW'(2); // R10: ignored after the trigger cycle
      end else begin
         trig_in = 1'b0;
      end
      if (A == 0) begin
         check(frozen == 1'b1, "R4", "frozen after zero-length trigger", int'(frozen), 1);
      end else begin
         for (int i = 1; i < A; i++) tick();
         check(frozen == 1'b0, "R5", "frozen before final write", int'(frozen), 0);
         tick();
         trig_in = 1'b0;
         rearm   = 1'b0;
         check(frozen == 1'b1, "R5", "frozen after final write", int'(frozen), 1);
      end
      trig_in  = 1'b0;
      rearm    = 1'b0;
      g_last   = g_T + 16'(A);
      exp_stop = (base_addr + int'(16'(g_last - base_cyc))) % D;
      g_stop   = exp_stop;
      check(int'(stop_addr) == exp_stop, "R3", "stop address", int'(stop_addr), exp_stop);
   endtask

   task automatic do_rearm();
      tick();
      rearm = 1'b1;
      g_r   = cyc;
      tick();
      rearm = 1'b0;
      // R9: frozen cleared one cycle after the re-arm
      check(frozen == 1'b0, "R9", "frozen after rearm", int'(frozen), 0);
      base_addr = (g_stop + 1) % D;
      base_cyc  = g_r + 16'd1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      base_addr = 0;
      base_cyc  = 16'd0;
      check(frozen == 1'b0, "R1", "frozen after reset", int'(frozen), 0);
      check(stop_addr == '0, "R1", "stop address after reset", int'(stop_addr), 0);
   endtask

   task automatic t_first_capture();
      repeat (1100) tick();
      capture(300, 1'b0); // R1/R3: first write at address 0 fixes the stop address
      read_chk(0, g_last - 16'(D - 1), "R8");
      read_chk(1, g_last - 16'(D - 2), "R2");
      read_chk(D - 1 - 300, g_T, "R8");
      read_chk(D - 1, g_last, "R8");
   endtask

   task automatic t_frozen_ignore();
      int s0;
      s0 = int'(stop_addr);
      tick();
      post_len = '0;
      trig_in  = 1'b1;
      tick();
      trig_in = 1'b0;
      repeat (40) tick();
      check(frozen == 1'b1, "R6", "frozen after trigger while frozen", int'(frozen), 1);
      check(int'(stop_addr) == s0, "R6", "stop address held", int'(stop_addr), s0);
      read_chk(D - 1, g_last, "R6");
      read_chk(0, g_last - 16'(D - 1), "R6");
   endtask

   task automatic t_rearm_quick();
      prev_last = g_last;
      do_rearm();
      capture(0, 1'b0);
      read_chk(D - 1, g_T, "R4");
      read_chk(D - 2, g_r + 16'd1, "R9");
      read_chk(D - 3, prev_last, "R9");
   endtask

   task automatic t_post_disturb();
      do_rearm();
      repeat (1100) tick();
      capture(5, 1'b1); // R7 R10
      read_chk(D - 1, g_T + 16'd5, "R7");
      read_chk(D - 6, g_T, "R10");
   endtask

   task automatic t_max_len();
      do_rearm();
      repeat (1100) tick();
      capture(D - 1, 1'b0);
      read_chk(0, g_T, "R8");
      read_chk(D - 1, g_T + 16'(D - 1), "R3");
   endtask

   task automatic t_len_one();
      do_rearm();
      repeat (1100) tick();
      capture(1, 1'b0);
      read_chk(D - 2, g_T, "R3");
      read_chk(D - 1, g_T + 16'd1, "R2");
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_first_capture();
      t_frozen_ignore();
      t_rearm_quick();
      t_post_disturb();
      t_max_len();
      t_len_one();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule